// File: doc/BRIEF.md
# Buck Power-Stage Gate-Drive Mode Controller

This block is the synchronous mode logic that sits behind the gate drivers of a single buck phase. It decides, on every clock, whether the high-side (control) switch or the low-side (rectifier) switch may conduct. It also enables the bootstrap switch, the zero-crossing comparator and the supply undervoltage comparator, and it reports which operating mode the stage is in. The analog comparators and the pin level decoders sit outside the block. The supply arrives as a sampled code. The PWM and skip pins arrive already decoded into three levels: 0 = low, 1 = high, 2 or 3 = mid (tri-state).

The controller applies hysteresis to the supply code. It selects forced continuous conduction or diode-emulation (DCM) from the skip level, and it ends low-side conduction at a zero crossing when in DCM. When PWM rests mid-level it parks in a light-quiescent state. When both pins rest mid-level it parks in an ultra-low-quiescent state with the undervoltage comparator switched off. A skip low then wakes it through a timed delay. Every exit from a tri-state parking state runs a timed forced-CCM window before skip may select DCM again. An interlock with a programmable dead time keeps the two switches apart.

Timing windows are given in nanoseconds and converted to clock cycles from a clock-frequency parameter: `FCCM_NS` (default 4000) and `WAKE_NS` (default 40000, below 50 µs).

Top module: `gdm_ctrl`

## Requirements
- R1: After reset the block reports mode 0 (disabled) with both gate enables low. It leaves mode 0 only once `vdd_code_i` >= `UV_HI`. A code inside [`UV_HI`-`UV_HYST`, `UV_HI`) keeps the previous undervoltage decision. A code below `UV_HI`-`UV_HYST` returns the block to mode 0 with both enables low.
- R2: With PWM at level 1 (high), `hs_en_o` is high and `ls_en_o` is low, for any skip level.
- R3: With PWM at level 0 and skip at level 1, the block reports mode 2 (forced CCM): `ls_en_o` high, `hs_en_o` low, `zx_cmp_en_o` low.
- R4: With PWM at level 0 and skip at level 0, outside the forced window, the block reports mode 1 (DCM) with `zx_cmp_en_o` high. `ls_en_o` is high until `zx_i` is seen high. It then stays low, even after `zx_i` falls, until PWM next goes high.
- R5: With PWM mid (level 2 or 3) and skip not mid, both enables are low and the mode reads 3 (light quiescent).
- R6: With both PWM and skip mid, both enables are low, the mode reads 4 (ultra-low quiescent) and `uv_cmp_en_o` is low. A supply drop in that state does not change the mode.
- R7: On leaving mode 3 or the wake delay into switching, the block runs forced CCM for exactly `CLK_MHZ`*`FCCM_NS`/1000 cycles (mode 2, `zx_i` ignored) whatever skip says. Only then does skip level 0 give DCM.
- R8: In mode 4, skip at level 0 starts a wake delay of `CLK_MHZ`*`WAKE_NS`/1000 cycles. During the delay the mode still reads 4, the enables stay low and `uv_cmp_en_o` is high. After the delay the block follows the pins.
- R9: `boot_en_o` equals `ls_en_o` in every cycle.
- R10: `hs_en_o` and `ls_en_o` are never high together. When one turns off for the other, both stay low for exactly `DEAD_CYC` cycles.
- R11: If both pins are mid when undervoltage first clears, the block enters mode 4 with both enables low and does not switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vdd_code_i | input | VW | Sampled supply-voltage code |
| pwm_i | input | 2 | PWM level: 0 low, 1 high, 2/3 mid |
| skip_i | input | 2 | Skip level: 0 low, 1 high, 2/3 mid |
| zx_i | input | 1 | Zero-crossing detected |
| hs_en_o | output | 1 | High-side switch enable |
| ls_en_o | output | 1 | Low-side switch enable |
| boot_en_o | output | 1 | Bootstrap switch enable |
| zx_cmp_en_o | output | 1 | Zero-crossing comparator enable |
| uv_cmp_en_o | output | 1 | Undervoltage comparator enable |
| mode_o | output | 3 | 0 disabled, 1 DCM, 2 forced CCM, 3 light quiescent, 4 ultra-low quiescent |

## Verification
The bench builds the block with `CLK_MHZ`=2, which makes the forced-CCM window 8 cycles and the wake delay 80 cycles. With these values both windows can be counted edge to edge and still leave room for every mode transition. `DEAD_CYC`=3 makes the interlock gap long enough to count without being confused with the single register stage of the output. `UV_HI`=100 with `UV_HYST`=10 lets codes 95, 91 and 89 probe both sides of each threshold and the hysteresis band between them.

// File: rtl/gdm_pkg.sv
package gdm_pkg;

    typedef enum logic [2:0] {
        MD_OFF  = 3'd0,
        MD_DCM  = 3'd1,
        MD_FCCM = 3'd2,
        MD_LQ   = 3'd3,
        MD_ULQ  = 3'd4
    } mode_t;

    typedef enum logic [2:0] {
        ST_DIS,
        ST_RUN,
        ST_LQ,
        ST_ULQ,
        ST_WAKE
    } st_t;

    typedef struct packed {
        logic hs;
        logic ls;
    } gate_t;

    // level codes: 0 low, 1 high, 2/3 mid
    function automatic logic lvl_mid(input logic [1:0] v);
        return v[1];
    endfunction

    function automatic logic lvl_hi(input logic [1:0] v);
        return v == 2'd1;
    endfunction

    function automatic logic lvl_lo(input logic [1:0] v);
        return v == 2'd0;
    endfunction

    function automatic int unsigned ns_to_cyc(input int unsigned mhz, input int unsigned ns);
        int unsigned r;
        r = (mhz * ns) / 1000;
        return (r < 1) ? 1 : r;
    endfunction

    // parking decision once the supply is good
    function automatic st_t settle(input logic pwm_m, input logic skip_m);
        if (pwm_m && skip_m) return ST_ULQ;
        if (pwm_m)           return ST_LQ;
        return ST_RUN;
    endfunction

endpackage

// File: rtl/gdm_uvlo.sv
module gdm_uvlo #(
    parameter int VW      = 8,
    parameter int UV_HI   = 200,
    parameter int UV_HYST = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [VW-1:0] code,
    output logic          uv
);
    localparam logic [VW-1:0] TH_HI = VW'(UV_HI);
    localparam logic [VW-1:0] TH_LO = VW'(UV_HI - UV_HYST);

    always_ff @(posedge clk) begin
        if (rst) begin
            uv <= 1'b1;
        end else if (en) begin
            if (uv && code >= TH_HI)
                uv <= 1'b0;
            else if (!uv && code < TH_LO)
                uv <= 1'b1;
        end
    end
endmodule

// File: rtl/gdm_tmr.sv
module gdm_tmr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    input  logic         clr,
    output logic         busy,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (load)          cnt <= val;
        else if (clr)           cnt <= '0;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign last = (cnt == W'(1));
endmodule

// File: rtl/gdm_dead.sv
module gdm_dead
    import gdm_pkg::*;
#(
    parameter int DEAD_CYC = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  gate_t req,
    output gate_t gate
);
    logic on_ok;

    generate
        if (DEAD_CYC <= 1) begin : g_min
            assign on_ok = !gate.hs && !gate.ls;
        end else begin : g_cnt
            localparam int CW = $clog2(DEAD_CYC) + 1;
            localparam logic [CW-1:0] OFF_LIM = CW'(DEAD_CYC - 1);
            logic [CW-1:0] off_cnt;

            always_ff @(posedge clk) begin
                if (rst)                       off_cnt <= OFF_LIM;
                else if (gate.hs || gate.ls)   off_cnt <= '0;
                else if (off_cnt != OFF_LIM)   off_cnt <= off_cnt + 1'b1;
            end

            assign on_ok = !gate.hs && !gate.ls && (off_cnt == OFF_LIM);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            gate <= '0;
        end else begin
            gate.hs <= req.hs && !req.ls && (gate.hs || on_ok);
            gate.ls <= req.ls && !req.hs && (gate.ls || on_ok);
        end
    end
endmodule

// File: rtl/gdm_ctrl.sv
module gdm_ctrl
    import gdm_pkg::*;
#(
    parameter int VW       = 8,
    parameter int UV_HI    = 200,
    parameter int UV_HYST  = 20,
    parameter int CLK_MHZ  = 100,
    parameter int FCCM_NS  = 4000,
    parameter int WAKE_NS  = 40000,
    parameter int DEAD_CYC = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [VW-1:0] vdd_code_i,
    input  logic [1:0]    pwm_i,
    input  logic [1:0]    skip_i,
    input  logic          zx_i,
    output logic          hs_en_o,
    output logic          ls_en_o,
    output logic          boot_en_o,
    output logic          zx_cmp_en_o,
    output logic          uv_cmp_en_o,
    output logic [2:0]    mode_o
);
    localparam int CCM_CYC = ns_to_cyc(CLK_MHZ, FCCM_NS);
    localparam int WK_CYC  = ns_to_cyc(CLK_MHZ, WAKE_NS);
    localparam int CCW     = $clog2(CCM_CYC + 1);
    localparam int WKW     = $clog2(WK_CYC + 1);

    st_t   state_q, st_n;
    logic  uv_q;
    logic  ccm_ld, ccm_busy, ccm_last;
    logic  wk_ld, wk_busy, wk_last;
    logic  zx_seen_q;
    logic  pwm_m, pwm_h, pwm_l, skip_m, skip_l;
    logic  in_run, dcm_sel;
    gate_t req, gate;
    mode_t mode;

    assign pwm_m  = lvl_mid(pwm_i);
    assign pwm_h  = lvl_hi(pwm_i);
    assign pwm_l  = lvl_lo(pwm_i);
    assign skip_m = lvl_mid(skip_i);
    assign skip_l = lvl_lo(skip_i);

    gdm_uvlo #(.VW(VW), .UV_HI(UV_HI), .UV_HYST(UV_HYST)) u_uvlo (
        .clk  (clk),
        .rst  (rst),
        .en   (state_q != ST_ULQ),
        .code (vdd_code_i),
        .uv   (uv_q)
    );

    // next state
    always_comb begin
        st_n  = state_q;
        wk_ld = 1'b0;
        unique case (state_q)
            ST_DIS:  if (!uv_q) st_n = settle(pwm_m, skip_m);
            ST_ULQ:  if (skip_l) begin
                         st_n  = ST_WAKE;
                         wk_ld = 1'b1;
                     end
            ST_WAKE: if (uv_q)         st_n = ST_DIS;
                     else if (wk_last) st_n = settle(pwm_m, skip_m);
            default: if (uv_q)         st_n = ST_DIS;
                     else              st_n = settle(pwm_m, skip_m);
        endcase
        ccm_ld = (st_n == ST_RUN) && (state_q == ST_LQ || state_q == ST_WAKE);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_DIS;
        else     state_q <= st_n;
    end

    gdm_tmr #(.W(CCW)) u_ccm (
        .clk  (clk),
        .rst  (rst),
        .load (ccm_ld),
        .val  (CCW'(CCM_CYC)),
        .clr  (state_q != ST_RUN),
        .busy (ccm_busy),
        .last (ccm_last)
    );

    gdm_tmr #(.W(WKW)) u_wake (
        .clk  (clk),
        .rst  (rst),
        .load (wk_ld),
        .val  (WKW'(WK_CYC)),
        .clr  (state_q != ST_WAKE),
        .busy (wk_busy),
        .last (wk_last)
    );

    assign in_run  = (state_q == ST_RUN);
    assign dcm_sel = in_run && skip_l && !ccm_busy;

    // zero-crossing latch, cleared by the next high-side pulse
    always_ff @(posedge clk) begin
        if (rst || !in_run || pwm_h) zx_seen_q <= 1'b0;
        else if (dcm_sel && pwm_l && zx_i) zx_seen_q <= 1'b1;
    end

    always_comb begin
        req.hs = in_run && pwm_h;
        req.ls = in_run && pwm_l && !(dcm_sel && (zx_seen_q || zx_i));
    end

    gdm_dead #(.DEAD_CYC(DEAD_CYC)) u_dead (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .gate (gate)
    );

    always_comb begin
        unique case (state_q)
            ST_RUN:           mode = dcm_sel ? MD_DCM : MD_FCCM;
            ST_LQ:            mode = MD_LQ;
            ST_ULQ, ST_WAKE:  mode = MD_ULQ;
            default:          mode = MD_OFF;
        endcase
    end

    assign hs_en_o     = gate.hs;
    assign ls_en_o     = gate.ls;
    assign boot_en_o   = gate.ls;
    assign zx_cmp_en_o = dcm_sel;
    assign uv_cmp_en_o = (state_q != ST_ULQ);
    assign mode_o      = mode;

    logic unused_ok;
    assign unused_ok = ^{ccm_last, wk_busy};
endmodule

// File: rtl/gdm_ctrl_chk.sv
module gdm_ctrl_chk
    import gdm_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       hs_en_o,
    input logic       ls_en_o,
    input logic       boot_en_o,
    input logic       zx_cmp_en_o,
    input logic       uv_cmp_en_o,
    input logic [2:0] mode_o
);
    p_interlock_r10: assert property (@(posedge clk) disable iff (rst)
        !(hs_en_o && ls_en_o));

    p_gap_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_en_o) |-> !$past(hs_en_o));

    p_off_r1: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MD_OFF && $past(mode_o) == MD_OFF) |-> (!hs_en_o && !ls_en_o));

    p_lq_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MD_LQ && $past(mode_o) == MD_LQ) |-> (!hs_en_o && !ls_en_o));

    p_uv_off_r6: assert property (@(posedge clk) disable iff (rst)
        !uv_cmp_en_o |-> (mode_o == MD_ULQ && !hs_en_o && !ls_en_o));

    p_dcm_zx_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MD_DCM) |-> zx_cmp_en_o);

    p_boot_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(boot_en_o) |-> !hs_en_o);
endmodule

bind gdm_ctrl gdm_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .hs_en_o     (hs_en_o),
    .ls_en_o     (ls_en_o),
    .boot_en_o   (boot_en_o),
    .zx_cmp_en_o (zx_cmp_en_o),
    .uv_cmp_en_o (uv_cmp_en_o),
    .mode_o      (mode_o)
);

// File: tb/sim_gdm_ctrl.sv
`timescale 1ns/1ps
module sim_gdm_ctrl;
    localparam int VW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [VW-1:0] code;
    logic [1:0]    pwm, skip;
    logic          zx;
    logic          hs, ls, boot, zxen, uven;
    logic [2:0]    mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gdm_ctrl #(
        .VW(VW), .UV_HI(100), .UV_HYST(10), .CLK_MHZ(2),
        .FCCM_NS(4000), .WAKE_NS(40000), .DEAD_CYC(3)
    ) u0 (
        .clk(clk), .rst(rst), .vdd_code_i(code), .pwm_i(pwm), .skip_i(skip),
        .zx_i(zx), .hs_en_o(hs), .ls_en_o(ls), .boot_en_o(boot),
        .zx_cmp_en_o(zxen), .uv_cmp_en_o(uven), .mode_o(mode)
    );

    typedef struct packed {
        logic [1:0] pwm;
        logic [1:0] skip;
        logic       zx;
        logic [7:0] hold;
        logic       hs;
        logic       ls;
        logic       zxen;
        logic [2:0] mode;
        logic [3:0] tag;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 2'd1, 1'b0, 8'd12,  1'b0, 1'b1, 1'b0, 3'd2, 4'd3}, // R3 forced CCM
        '{2'd1, 2'd1, 1'b0, 8'd12,  1'b1, 1'b0, 1'b0, 3'd2, 4'd2}, // R2 high, skip high
        '{2'd1, 2'd0, 1'b0, 8'd12,  1'b1, 1'b0, 1'b1, 3'd1, 4'd2}, // R2 high, skip low
        '{2'd0, 2'd0, 1'b0, 8'd12,  1'b0, 1'b1, 1'b1, 3'd1, 4'd4}, // R4 DCM conducting
        '{2'd0, 2'd0, 1'b1, 8'd12,  1'b0, 1'b0, 1'b1, 3'd1, 4'd4}, // R4 zero crossing
        '{2'd0, 2'd0, 1'b0, 8'd12,  1'b0, 1'b0, 1'b1, 3'd1, 4'd4}, // R4 stays off
        '{2'd1, 2'd0, 1'b0, 8'd12,  1'b1, 1'b0, 1'b1, 3'd1, 4'd4}, // R4 re-arm by high
        '{2'd0, 2'd0, 1'b0, 8'd12,  1'b0, 1'b1, 1'b1, 3'd1, 4'd4}, // R4 conducts again
        '{2'd2, 2'd0, 1'b0, 8'd12,  1'b0, 1'b0, 1'b0, 3'd3, 4'd5}, // R5 light quiescent
        '{2'd2, 2'd1, 1'b0, 8'd12,  1'b0, 1'b0, 1'b0, 3'd3, 4'd5}, // R5 skip high
        '{2'd0, 2'd0, 1'b0, 8'd20,  1'b0, 1'b1, 1'b1, 3'd1, 4'd7}, // R7 after window
        '{2'd2, 2'd3, 1'b0, 8'd12,  1'b0, 1'b0, 1'b0, 3'd4, 4'd6}, // R6 both mid
        '{2'd0, 2'd0, 1'b0, 8'd100, 1'b0, 1'b1, 1'b1, 3'd1, 4'd8}  // R8 wake then run
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int cnt;
        rst = 1'b1; code = '0; pwm = 2'd0; skip = 2'd1; zx = 1'b0;
        step(4);
        chk("R1 reset mode", mode, 0);
        chk("R1 reset hs", hs, 0);
        chk("R1 reset ls", ls, 0);
        chk("R1 reset uv_en", uven, 1);
        rst = 1'b0;

        // R1 hysteresis
        code = 8'd95;  step(6);
        chk("R1 below upper", mode, 0);
        code = 8'd100; step(6);
        chk("R1 clear mode", mode, 2);
        chk("R1 clear ls", ls, 1);
        code = 8'd91;  step(6);
        chk("R1 band holds", mode, 2);
        code = 8'd89;  step(6);
        chk("R1 reassert mode", mode, 0);
        chk("R1 reassert ls", ls, 0);
        code = 8'd120; step(6);

        for (int i = 0; i < NV; i++) begin
            pwm = TBL[i].pwm; skip = TBL[i].skip; zx = TBL[i].zx;
            step(int'(TBL[i].hold));
            chk($sformatf("R%0d vec%0d hs", TBL[i].tag, i), hs, TBL[i].hs);
            chk($sformatf("R%0d vec%0d ls", TBL[i].tag, i), ls, TBL[i].ls);
            chk($sformatf("R%0d vec%0d zxen", TBL[i].tag, i), zxen, TBL[i].zxen);
            chk($sformatf("R%0d vec%0d mode", TBL[i].tag, i), mode, TBL[i].mode);
            chk($sformatf("R9 vec%0d boot", i), boot, ls);
        end

        // R10 dead time: low side on, switch to high
        pwm = 2'd1;
        cnt = 0;
        for (int k = 0; k < 10; k++) begin
            step(1);
            if (!hs && !ls) cnt++;
        end
        chk("R10 gap cycles", cnt, 3);
        chk("R10 hs after gap", hs, 1);

        // R7 forced window length, zx ignored inside it
        pwm = 2'd2; skip = 2'd0; step(6);
        zx = 1'b1; pwm = 2'd0;
        cnt = 0;
        for (int k = 1; k <= 20; k++) begin
            step(1);
            if (mode == 3'd2) cnt++;
            if (k == 5) chk("R7 ls in window", ls, 1);
        end
        chk("R7 window cycles", cnt, 8);
        chk("R7 DCM after window", mode, 1);
        chk("R7 zx honoured after", ls, 0);
        zx = 1'b0;

        // R6 comparator off, R8 wake delay
        pwm = 2'd2; skip = 2'd2; step(6);
        chk("R6 mode", mode, 4);
        chk("R6 uv_en", uven, 0);
        code = 8'd0; step(6);
        chk("R6 supply drop ignored", mode, 4);
        code = 8'd120; step(2);
        skip = 2'd0;
        cnt = 0;
        for (int k = 1; k <= 100; k++) begin
            step(1);
            if (mode == 3'd4) cnt++;
            if (k == 1) chk("R8 uv_en in wake", uven, 1);
            if (k == 40) chk("R8 ls in wake", ls, 0);
        end
        chk("R8 wake cycles", cnt, 80);
        chk("R8 after wake mode", mode, 3);

        // R6: comparator re-enabled by wake sees a low supply
        skip = 2'd2; step(6);
        code = 8'd0; skip = 2'd0; step(10);
        chk("R6 low supply after wake", mode, 0);

        // R11 both mid at first clear
        rst = 1'b1; code = 8'd0; pwm = 2'd2; skip = 2'd2; step(3);
        rst = 1'b0; code = 8'd120; step(8);
        chk("R11 mode", mode, 4);
        chk("R11 hs", hs, 0);
        chk("R11 ls", ls, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule